// File: doc/BRIEF.md
# Decision-Tree Peripheral Route Lookup

This block turns a peripheral key into a short route number by walking a binary decision tree kept in a local table of node records. The 12-bit key is built inside the block from a 4-bit unit selector (upper bits) and an 8-bit peripheral selector (lower bits). Every node names one key bit to test and carries two branches, one for a tested bit of 0 and one for a tested bit of 1. Each branch is either a link to another node or a final 8-bit route value.

A lookup begins at node 0 when `start` is seen while idle. The block takes one tree step per clock. It finishes with a single-cycle `done` pulse, and `found` and `route` report the outcome. A lookup that does not reach a leaf within the step limit, or that follows a link past the end of the table, finishes with `found` low. The table is loaded through a simple synchronous write port. Reset clears every record to zero.

Top module: `tree_route_lookup`

## Requirements
- R1: The key is formed as unit selector in bits [11:8] and peripheral selector in bits [7:0]. A node testing bit 11 follows the unit selector's bit 3, and a node testing bit 8 follows the unit selector's bit 0.
- R2: A node record is 22 bits wide. Bits [21:18] give the tested key bit. Bit 17 is the link flag of the 0-branch and bits [16:9] are its value. Bit 8 is the link flag of the 1-branch and bits [7:0] are its value.
- R3: A walk starts at node 0. If the tested key bit is 1, the 1-branch is taken; otherwise the 0-branch is taken. A tested bit index of 12 or more reads as 0.
- R4: When the taken branch has its link flag clear, the lookup ends with `found`=1 and `route` equal to that branch's value. When the flag is set, the value is the index of the next node.
- R5: A lookup takes at most 16 steps. If the 16th step takes another link, the lookup ends with `found`=0.
- R6: A link to node index 255 or above ends the lookup at once with `found`=0, in the step that took the link.
- R7: One step is taken per clock. A lookup of n steps raises `done` n cycles after the edge that accepted `start`.
- R8: `done` is high for exactly one cycle per lookup, and `found` and `route` are valid in that cycle.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` pulse while busy is ignored: it neither changes the key of the running lookup nor produces another `done`.
- R10: After reset `busy`, `done`, `found` and `route` are 0, and every node record is 0, so a lookup then ends after one step with `found`=1 and `route`=0.
- R11: A write with `tbl_we` high stores `tbl_wdata` into node `tbl_waddr` at the clock edge, and later lookups use the new record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Node table write enable |
| tbl_waddr | input | 8 | Node index to write |
| tbl_wdata | input | 22 | Node record to write |
| start | input | 1 | Begin a lookup when idle |
| unit_sel | input | 4 | Unit selector, upper key bits |
| periph_sel | input | 8 | Peripheral selector, lower key bits |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup reached a leaf (valid with done) |
| route | output | 8 | Leaf value (valid with done) |

## Verification
A wrong node index or step count in the walker shows at the ports as a wrong `route` value or a completion in the wrong cycle. Because the latency equals the number of steps, a drifted step counter changes when `done` rises within one lookup, and the bench measures that latency on every lookup. A corrupted captured key sends the walk down the wrong branch, so with a tree whose leaf encodes the bit-reversed key, the first wrong decision shows up as a wrong `route` when that same lookup completes. Sweeping every key through a seven-level tree, and then driving the step limit and far-link corners, exposes these faults without looking inside the block.

// File: rtl/trl_pkg.sv
package trl_pkg;

    // Field widths of one tree node record
    localparam int SEL_W = 4;   // tested key bit index
    localparam int VAL_W = 8;   // branch value: next node or final route

    // Packed so that bit positions follow the record layout:
    // [21:18] sel, [17] zero_link, [16:9] zero_val, [8] one_link, [7:0] one_val
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             zero_link;
        logic [VAL_W-1:0] zero_val;
        logic             one_link;
        logic [VAL_W-1:0] one_val;
    } tree_node_t;

    localparam int NODE_W = $bits(tree_node_t);

    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_WALK = 1'b1
    } walk_phase_t;

endpackage

// File: rtl/trl_table.sv
module trl_table
    import trl_pkg::*;
#(
    parameter int DEPTH = 255,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  tree_node_t    wr_data,
    input  logic [AW-1:0] rd_addr,
    output tree_node_t    rd_node
);

    tree_node_t mem_q [DEPTH];

    logic wr_ok;
    assign wr_ok = wr_en && (int'(wr_addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read so that one node is consumed per cycle
    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_node = mem_q[rd_addr];
        end else begin
            rd_node = '0;
        end
    end

endmodule

// File: rtl/trl_branch.sv
module trl_branch
    import trl_pkg::*;
#(
    parameter int KEY_W = 12
) (
    input  tree_node_t       node,
    input  logic [KEY_W-1:0] key,
    output logic             take_link,
    output logic [VAL_W-1:0] take_val
);

    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] key_ext;
    logic            tested;

    // Bit indices beyond the key width read as zero
    assign key_ext = SPAN'(key);
    assign tested  = key_ext[node.sel];

    always_comb begin
        if (tested) begin
            take_link = node.one_link;
            take_val  = node.one_val;
        end else begin
            take_link = node.zero_link;
            take_val  = node.zero_val;
        end
    end

endmodule

// File: rtl/trl_walker.sv
module trl_walker
    import trl_pkg::*;
#(
    parameter int KEY_W     = 12,
    parameter int DEPTH     = 255,
    parameter int AW        = 8,
    parameter int MAX_STEPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key_in,
    input  logic             br_link,
    input  logic [VAL_W-1:0] br_val,
    output logic [KEY_W-1:0] key_cur,
    output logic [AW-1:0]    node_addr,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic [VAL_W-1:0] route
);

    localparam int STEP_W = $clog2(MAX_STEPS + 1);

    typedef struct packed {
        walk_phase_t      phase;
        logic [KEY_W-1:0] key;
        logic [AW-1:0]    node;
        logic [STEP_W-1:0] steps;
        logic             done;
        logic             found;
        logic [VAL_W-1:0] route;
    } walk_state_t;

    walk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            WK_IDLE: begin
                if (start) begin
                    st_d.phase = WK_WALK;
                    st_d.key   = key_in;
                    st_d.node  = '0;
                    st_d.steps = '0;
                end
            end
            WK_WALK: begin
                if (!br_link) begin
                    st_d.phase = WK_IDLE;
                    st_d.done  = 1'b1;
                    st_d.found = 1'b1;
                    st_d.route = br_val;
                end else if (int'(br_val) >= DEPTH) begin
                    st_d.phase = WK_IDLE;
                    st_d.done  = 1'b1;
                    st_d.found = 1'b0;
                    st_d.route = '0;
                end else if (st_q.steps == STEP_W'(MAX_STEPS - 1)) begin
                    st_d.phase = WK_IDLE;
                    st_d.done  = 1'b1;
                    st_d.found = 1'b0;
                    st_d.route = '0;
                end else begin
                    st_d.node  = AW'(br_val);
                    st_d.steps = st_q.steps + 1'b1;
                end
            end
            default: st_d.phase = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_cur   = st_q.key;
    assign node_addr = st_q.node;
    assign busy      = (st_q.phase == WK_WALK);
    assign done      = st_q.done;
    assign found     = st_q.found;
    assign route     = st_q.route;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(key_cur));

    // R5
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(st_q.steps) < MAX_STEPS));

    // R6
    far_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && br_link && (int'(br_val) >= DEPTH)) |=> (done && !found));

    // R4
    leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !br_link) |=> (done && found && route == $past(br_val)));

endmodule

// File: rtl/tree_route_lookup.sv
module tree_route_lookup
    import trl_pkg::*;
#(
    parameter int UNIT_W    = 4,
    parameter int PERIPH_W  = 8,
    parameter int DEPTH     = 255,
    parameter int MAX_STEPS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_we,
    input  logic [$clog2(DEPTH)-1:0] tbl_waddr,
    input  logic [NODE_W-1:0]     tbl_wdata,
    input  logic                  start,
    input  logic [UNIT_W-1:0]     unit_sel,
    input  logic [PERIPH_W-1:0]   periph_sel,
    output logic                  busy,
    output logic                  done,
    output logic                  found,
    output logic [VAL_W-1:0]      route
);

    localparam int KEY_W = UNIT_W + PERIPH_W;
    localparam int AW    = $clog2(DEPTH);

    logic [KEY_W-1:0] key_in;
    logic [KEY_W-1:0] key_cur;
    logic [AW-1:0]    node_addr;
    tree_node_t       cur_node;
    logic             br_link;
    logic [VAL_W-1:0] br_val;

    // R1: unit selector above peripheral selector
    assign key_in = {unit_sel, periph_sel};

    trl_table #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_waddr),
        .wr_data (tree_node_t'(tbl_wdata)),
        .rd_addr (node_addr),
        .rd_node (cur_node)
    );

    trl_branch #(
        .KEY_W (KEY_W)
    ) u_branch (
        .node      (cur_node),
        .key       (key_cur),
        .take_link (br_link),
        .take_val  (br_val)
    );

    trl_walker #(
        .KEY_W     (KEY_W),
        .DEPTH     (DEPTH),
        .AW        (AW),
        .MAX_STEPS (MAX_STEPS)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key_in    (key_in),
        .br_link   (br_link),
        .br_val    (br_val),
        .key_cur   (key_cur),
        .node_addr (node_addr),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .route     (route)
    );

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_tree_route_lookup.sv
`timescale 1ns/1ps
module sim_tree_route_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_waddr = '0;
    logic [21:0] tbl_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  unit_sel = '0;
    logic [7:0]  periph_sel = '0;
    logic        busy, done, found;
    logic [7:0]  route;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tree_route_lookup u0 (
        .clk (clk), .rst_n (rst_n),
        .tbl_we (tbl_we), .tbl_waddr (tbl_waddr), .tbl_wdata (tbl_wdata),
        .start (start), .unit_sel (unit_sel), .periph_sel (periph_sel),
        .busy (busy), .done (done), .found (found), .route (route)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input int sel, input bit zl, input int zv,
                                        input bit ol, input int ov);
        return {4'(sel), zl, 8'(zv), ol, 8'(ov)};
    endfunction

    task automatic wr(input int addr, input logic [21:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 8'(addr); tbl_wdata = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Runs one lookup; lat counts edges from the start edge to the done edge
    task automatic look(input int u, input int p, input bit poke,
                        output int f, output int r, output int lat);
        @(negedge clk);
        unit_sel = 4'(u); periph_sel = 8'(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) chk("R9 busy after start", busy, 1);
        lat = 0; f = -1; r = -1;
        while (1) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; unit_sel = ~4'(u); periph_sel = ~8'(p);
            end else begin
                start = 1'b0;
            end
            if (done) begin
                f = found; r = route;
                break;
            end
            if (lat > 40) begin
                chk("R7 lookup never completed", 0, 1);
                break;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R8 done single cycle", done, 0);
        chk("R9 busy low after done", busy, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int f, r, lat, exp;
        repeat (3) @(negedge clk);
        chk("R10 busy at reset", busy, 0);
        chk("R10 done at reset", done, 0);
        chk("R10 found at reset", found, 0);
        chk("R10 route at reset", route, 0);
        rst_n = 1'b1;

        // R10: cleared table gives a leaf of 0 at node 0
        look(5, 8'hA3, 1'b0, f, r, lat);
        chk("R10 cleared table found", f, 1);
        chk("R10 cleared table route", r, 0);
        chk("R10 cleared table latency", lat, 1);

        // R1/R2/R11: node 0 tests bit 11 (unit bit 3)
        wr(0, mk(11, 1'b0, 8'h11, 1'b0, 8'h22));
        look(8, 0, 1'b0, f, r, lat);
        chk("R1 bit 11 set route", r, 8'h22);
        look(7, 8'hFF, 1'b0, f, r, lat);
        chk("R1 bit 11 clear route", r, 8'h11);
        wr(0, mk(8, 1'b0, 8'h33, 1'b0, 8'h44));
        look(1, 0, 1'b0, f, r, lat);
        chk("R1 bit 8 set route", r, 8'h44);
        look(14, 8'hFF, 1'b0, f, r, lat);
        chk("R1 bit 8 clear route", r, 8'h33);
        // R3: index beyond key width reads as 0
        wr(0, mk(13, 1'b0, 8'h55, 1'b0, 8'h66));
        look(15, 8'hFF, 1'b0, f, r, lat);
        chk("R3 out of key bit takes zero branch", r, 8'h55);

        // Seven-level tree over key bits 0..6; leaf value = bit-reversed key[6:0]
        for (int n = 0; n < 127; n++) begin
            int lvl;
            lvl = $clog2(n + 2) - 1;
            if (lvl < 6) wr(n, mk(lvl, 1'b1, 2*n+1, 1'b1, 2*n+2));
            else         wr(n, mk(lvl, 1'b0, (n-63)*2, 1'b0, (n-63)*2+1));
        end
        for (int k = 0; k < 4096; k++) begin
            exp = 0;
            for (int b = 0; b < 7; b++) exp |= ((k >> b) & 1) << (6 - b);
            look(k >> 8, k & 255, 1'b0, f, r, lat);
            chk("R3 R4 sweep found", f, 1);
            chk("R3 R4 sweep route", r, exp);
            chk("R7 sweep latency", lat, 7);
        end
        // R9: start during walk ignored
        look(2, 8'h5B, 1'b1, f, r, lat);
        chk("R9 ignored start route", r, 8'b1101101);
        chk("R9 ignored start latency", lat, 7);
        repeat (10) begin
            @(negedge clk);
            chk("R9 no extra done", done, 0);
        end

        // R5: chain of 16 links
        for (int n = 0; n < 16; n++) wr(n, mk(0, 1'b1, n+1, 1'b1, n+1));
        wr(16, mk(0, 1'b0, 8'h5A, 1'b0, 8'h5A));
        look(0, 0, 1'b0, f, r, lat);
        chk("R5 step limit not found", f, 0);
        chk("R5 step limit latency", lat, 16);
        wr(15, mk(0, 1'b0, 8'h3C, 1'b0, 8'h3C));
        look(0, 1, 1'b0, f, r, lat);
        chk("R5 leaf at step 16 found", f, 1);
        chk("R5 leaf at step 16 route", r, 8'h3C);
        chk("R7 leaf at step 16 latency", lat, 16);

        // R6: far link
        wr(0, mk(0, 1'b1, 255, 1'b1, 254));
        wr(254, mk(0, 1'b0, 8'h77, 1'b0, 8'h77));
        look(0, 0, 1'b0, f, r, lat);
        chk("R6 link 255 not found", f, 0);
        chk("R6 link 255 latency", lat, 1);
        look(0, 1, 1'b0, f, r, lat);
        chk("R6 link 254 found", f, 1);
        chk("R6 link 254 route", r, 8'h77);
        chk("R6 link 254 latency", lat, 2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule